// File: doc/BRIEF.md
# Double-Sample Compare Domain Crossing

This block carries a multi-bit value from one clock domain into a second, unrelated clock domain without any request/acknowledge exchange and without Gray coding. On the source side a holding register keeps the value steady. It changes only when a load strobe is presented. On the destination side the crossing bus is captured twice on consecutive destination cycles. In the following cycle the two captures are compared.

When the two samples agree, the value is accepted. It is written to the output data register, and a single-cycle valid strobe goes with it. When they disagree, the source was changing inside the capture window and the pair is thrown away. The block then starts a fresh capture pair at once, and keeps retrying until two samples match. No skew or phase relation between the two clocks is assumed. The only condition is that the source value stays stable for the capture window.

Top module: `dual_sample_xfer`

## Requirements
- R1: The source holding register takes `srcData` on a rising `srcClk` edge where `srcLoad` is 1. Otherwise it keeps its value, and while `srcRst` is 1 it is cleared to 0.
- R2: After `dstRst` is released, the destination repeats a fixed three-cycle schedule: capture the first sample, capture the second sample, compare. On a steady source, the first `dstValid` is high in the third cycle after release.
- R3: When the two samples are equal, `dstData` takes the sampled value and `dstValid` is 1 for exactly one destination cycle.
- R4: When the two samples differ, `dstValid` stays 0 and `dstData` keeps its previous value.
- R5: A new capture pair starts in the cycle after every compare. A steady source therefore gives exactly one accept every three destination cycles, and a changing source that then settles is accepted again within six cycles.
- R6: Every value presented with `dstValid` is a value the source holding register actually held. It is never a mix of bits from two values.
- R7: While `dstRst` is 1, `dstValid` is 0 and `dstData` is 0 in the following cycle.
- R8: The data width is set by the parameter `DATA_W`. All data paths follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | 1 | Source domain clock |
| srcRst | input | 1 | Source synchronous reset, active high |
| srcLoad | input | 1 | Load strobe for the source holding register |
| srcData | input | DATA_W | Value to be loaded on the source side |
| dstClk | input | 1 | Destination domain clock |
| dstRst | input | 1 | Destination synchronous reset, active high |
| dstValid | output | 1 | One-cycle strobe marking an accepted value |
| dstData | output | DATA_W | Last accepted value |

## Verification
The bench uses a 4-bit instance. It sweeps all sixteen values through a steady source at an unrelated source clock, which shows that each value crosses intact. A burst in which the source changes on every one of its faster clock edges must produce no accept and leave the output untouched. Once that burst stops, an accept of the final value must follow, which separates the discard case from the retry case. A long stretch of loads at uneven intervals is checked against a bench model of the source register's recent history, so that a mixed value cannot slip through. The accept count over a steady window pins down the three-cycle cadence.

// File: rtl/dsx_pkg.sv
package dsx_pkg;
  typedef struct packed {
    logic loadFirst;
    logic loadSecond;
    logic checkPair;
  } dsxStrobes_t;

  typedef enum logic [1:0] {
    PH_FIRST  = 2'd0,
    PH_SECOND = 2'd1,
    PH_CHECK  = 2'd2
  } dsxPhase_e;
endpackage

// File: rtl/dsx_src_hold.sv
module dsx_src_hold #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] held
);
  always_ff @(posedge clk) begin
    if (rst)       held <= '0;
    else if (load) held <= din;
  end

  // R1: without a load strobe the crossing bus does not move
  assert_src_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(held));
endmodule

// File: rtl/dsx_dst_ctrl.sv
module dsx_dst_ctrl
  import dsx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  output dsxStrobes_t strobes
);
  dsxPhase_e phase;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FIRST;
    else begin
      unique case (phase)
        PH_FIRST:  phase <= PH_SECOND;
        PH_SECOND: phase <= PH_CHECK;
        default:   phase <= PH_FIRST;
      endcase
    end
  end

  always_comb begin
    strobes = '0;
    strobes.loadFirst  = !rst && (phase == PH_FIRST);
    strobes.loadSecond = !rst && (phase == PH_SECOND);
    strobes.checkPair  = !rst && (phase == PH_CHECK);
  end

  // R2: the second capture is always followed by a compare
  assert_second_then_check_R2: assert property (@(posedge clk) disable iff (rst)
    strobes.loadSecond |=> strobes.checkPair);
  // R5: a new pair starts right after each compare
  assert_retry_start_R5: assert property (@(posedge clk) disable iff (rst)
    strobes.checkPair |=> strobes.loadFirst);
endmodule

// File: rtl/dsx_dst_datapath.sv
module dsx_dst_datapath
  import dsx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  dsxStrobes_t       strobes,
  input  logic [DATA_W-1:0] crossBus,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);
  logic [DATA_W-1:0] capA;
  logic [DATA_W-1:0] capB;
  logic              pairMatch;

  assign pairMatch = (capA == capB);

  always_ff @(posedge clk) begin
    if (rst) begin
      capA     <= '0;
      capB     <= '0;
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      if (strobes.loadFirst)  capA <= crossBus;
      if (strobes.loadSecond) capB <= crossBus;
      outValid <= strobes.checkPair && pairMatch;
      if (strobes.checkPair && pairMatch) outData <= capA;
    end
  end

  // R3: an accepted value is the one both samples agreed on
  assert_accept_match_R3: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (capA == capB) && (outData == capA));
  // R3: the valid strobe lasts one cycle
  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);
  // R4: output data only moves together with a valid strobe
  assert_hold_data_R4: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outData));
  // R2: valid only follows a compare cycle
  assert_valid_after_check_R2: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(strobes.checkPair));
  // R7: reset clears the output side
  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> !outValid && (outData == '0));
endmodule

// File: rtl/dual_sample_xfer.sv
module dual_sample_xfer
  import dsx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              srcClk,
  input  logic              srcRst,
  input  logic              srcLoad,
  input  logic [DATA_W-1:0] srcData,
  input  logic              dstClk,
  input  logic              dstRst,
  output logic              dstValid,
  output logic [DATA_W-1:0] dstData
);
  logic [DATA_W-1:0] crossBus;
  dsxStrobes_t       strobes;

  dsx_src_hold #(.DATA_W(DATA_W)) u_src (
    .clk(srcClk), .rst(srcRst), .load(srcLoad), .din(srcData), .held(crossBus)
  );

  dsx_dst_ctrl u_ctrl (
    .clk(dstClk), .rst(dstRst), .strobes(strobes)
  );

  dsx_dst_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(dstClk), .rst(dstRst), .strobes(strobes), .crossBus(crossBus),
    .outValid(dstValid), .outData(dstData)
  );
endmodule

// File: tb/tb_dual_sample_xfer.sv
`timescale 1ns/1ps
module tb_dual_sample_xfer;
  localparam int W = 4;

  logic         srcClk = 1'b0;
  logic         dstClk = 1'b0;
  logic         srcRst = 1'b1;
  logic         dstRst = 1'b1;
  logic         srcLoad = 1'b0;
  logic [W-1:0] srcData = '0;
  logic         dstValid;
  logic [W-1:0] dstData;

  real srcHalf = 3.5;
  int  checks = 0;
  int  fails = 0;
  int  monFails = 0;
  int  monAccepts = 0;
  int  validCount = 0;
  bit  countOn = 1'b0;
  bit  done = 1'b0;

  logic [W-1:0] hist [8];

  dual_sample_xfer #(.DATA_W(W)) dut (
    .srcClk(srcClk), .srcRst(srcRst), .srcLoad(srcLoad), .srcData(srcData),
    .dstClk(dstClk), .dstRst(dstRst), .dstValid(dstValid), .dstData(dstData)
  );

  always #2 dstClk = ~dstClk;
  always #(srcHalf) srcClk = ~srcClk;

  // Bench model of the source register's recent history (R1, R6)
  always @(posedge srcClk) begin
    if (srcRst) begin
      for (int i = 0; i < 8; i++) hist[i] <= '0;
    end else if (srcLoad) begin
      for (int i = 1; i < 8; i++) hist[i] <= hist[i-1];
      hist[0] <= srcData;
    end
  end

  // R6 monitor: each accepted value must be a recently held source value
  always @(negedge dstClk) begin
    if (!dstRst && dstValid) begin
      bit found;
      found = 1'b0;
      for (int i = 0; i < 8; i++) if (hist[i] == dstData) found = 1'b1;
      monAccepts++;
      if (!found) begin
        monFails++;
        $display("FAIL R6: accepted %0h not in source history (expected one of last held values)", dstData);
      end
    end
    if (countOn && dstValid) validCount++;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic loadVal(input logic [W-1:0] v);
    @(negedge srcClk);
    srcData = v;
    srcLoad = 1'b1;
    @(negedge srcClk);
    srcLoad = 1'b0;
  endtask

  task automatic dstWait(input int n);
    for (int i = 0; i < n; i++) @(negedge dstClk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] lastVal;
    logic [W-1:0] heldBefore;
    // R7: reset state
    dstWait(3);
    check("R7 valid in reset", dstValid, 0);
    check("R7 data in reset", dstData, 0);

    // R2: schedule after release, source already steady at 0xA
    @(negedge srcClk); srcRst = 1'b0;
    loadVal(4'hA);
    repeat (3) @(negedge srcClk);
    @(negedge dstClk); dstRst = 1'b0;
    @(negedge dstClk); check("R2 cycle1 valid", dstValid, 0);
    @(negedge dstClk); check("R2 cycle2 valid", dstValid, 0);
    @(negedge dstClk); check("R2 cycle3 valid", dstValid, 1);
    check("R2 cycle3 data", dstData, 4'hA);
    @(negedge dstClk); check("R3 one-cycle strobe", dstValid, 0);

    // R3/R8: sweep every 4-bit value through a steady source
    for (int v = 0; v < 16; v++) begin
      loadVal(v[W-1:0]);
      dstWait(12);
      check("R3 sweep value", dstData, v);
    end

    // R5: cadence on a steady source
    countOn = 1'b1; validCount = 0;
    dstWait(30);
    countOn = 1'b0;
    check("R5 accepts in 30 cycles", validCount, 10);

    // R1: data changes without a load strobe are ignored
    @(negedge srcClk); srcData = 4'h3;
    dstWait(15);
    check("R1 no load ignored", dstData, 15);

    // R4: source changing on every faster source edge -> no accept
    heldBefore = dstData;
    srcHalf = 1.5;
    dstWait(2);
    @(negedge srcClk);
    srcLoad = 1'b1;
    srcData = 4'h0;
    for (int i = 0; i < 4; i++) begin
      @(negedge srcClk); srcData = srcData + 1'b1;
    end
    countOn = 1'b1; validCount = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge srcClk); srcData = srcData + 1'b1;
    end
    countOn = 1'b0;
    check("R4 no accept while changing", validCount, 0);
    check("R4 data held", dstData, heldBefore);

    // R5: retry succeeds once the source settles
    @(negedge srcClk);
    lastVal = srcData;
    srcLoad = 1'b0;
    countOn = 1'b1; validCount = 0;
    dstWait(8);
    countOn = 1'b0;
    check("R5 retry accepted", (validCount > 0) ? 1 : 0, 1);
    check("R5 retry value", dstData, lastVal);

    // R6: uneven loads on an unrelated source clock
    srcHalf = 2.3;
    for (int i = 0; i < 200; i++) begin
      loadVal(4'((i * 5 + 3) % 16));
      repeat ((i * 7) % 5) @(negedge srcClk);
    end
    dstWait(12);
    check("R6 final value", dstData, (199 * 5 + 3) % 16);
    check("R6 no mixed accept", monFails, 0);
    check("R6 accepts observed", (monAccepts > 20) ? 1 : 0, 1);

    // R1: source reset clears holding register, destination accepts 0
    @(negedge srcClk); srcRst = 1'b1;
    repeat (2) @(negedge srcClk); srcRst = 1'b0;
    dstWait(12);
    check("R1 source reset", dstData, 0);

    // R7: destination reset mid-run
    loadVal(4'h9);
    dstWait(12);
    @(negedge dstClk); dstRst = 1'b1;
    @(negedge dstClk);
    check("R7 valid after reset", dstValid, 0);
    check("R7 data after reset", dstData, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule